// File: doc/BRIEF.md
# Dual-Byte Registered Bus Transceiver

This block connects two 16-bit buses, called A and B, through non-inverting data paths in both directions. The 16 bits are split into two independent byte halves. Each half has its own set of six controls: one capture clock per direction, one source select per direction and one drive enable per direction. For each direction, the select chooses the source of the outputs. It can pass the opposite bus input straight through, or it can drive a value held in that direction's capture register.

Each capture register loads the bus input it watches on the rising edge of its own clock. The load happens whatever the select and enable settings are. A half can therefore record traffic on a bus while its outputs are idle, and replay that value later. The bidirectional pins are modelled as three separate vectors per bus: an input, an output and an output enable. An output-enable bit is high exactly when the matching output bit is driven. While it is low, the output data bit carries no meaning.

Enabling both directions of a half with both selects in pass-through mode makes each bus copy the other. An external loop then keeps its value without using the capture registers.

Top module: `xcvr_dual_byte`

## Requirements
- R1: On a rising edge of `ab_clk[h]`, half h loads its 8 bits of `a_in` into its A-side register, whatever the values of `ab_sel[h]` and `ab_en[h]`. A later storage-mode read returns that value.
- R2: On a rising edge of `ba_clk[h]`, half h loads its 8 bits of `b_in` into its B-side register, whatever the values of `ba_sel[h]` and `ba_en_n[h]`.
- R3: With `ab_sel[h]`=0 (pass-through) and the half's B outputs driven, the half's bits of `b_out` equal the same bits of `a_in`, without inversion, in the same cycle.
- R4: With `ab_sel[h]`=1 (stored) and the half's B outputs driven, the half's bits of `b_out` equal the A-side register of that half.
- R5: With `ba_sel[h]`=0 the driven bits of `a_out` for half h equal the same bits of `b_in`. With `ba_sel[h]`=1 they equal the B-side register of that half.
- R6: `ab_en[h]` is active high. The half's 8 bits of `b_oe` are all 1 while it is 1 and all 0 while it is 0.
- R7: `ba_en_n[h]` is active low. The half's 8 bits of `a_oe` are all 1 while it is 0 and all 0 while it is 1.
- R8: With both selects at 0 and both directions enabled, the half's bits of `b_out` copy `a_in` and its bits of `a_out` copy `b_in`, at the same time.
- R9: Half 0 owns bits 7:0 and half 1 owns bits 15:8. Changing the controls or clocks of one half never changes the outputs, enables or stored values of the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_clk | input | 2 | Per-half capture clock for the A-side register (rising edge) |
| ba_clk | input | 2 | Per-half capture clock for the B-side register (rising edge) |
| ab_sel | input | 2 | Per-half source for B outputs: 0 pass-through, 1 stored |
| ba_sel | input | 2 | Per-half source for A outputs: 0 pass-through, 1 stored |
| ab_en | input | 2 | Per-half B-output drive enable, active high |
| ba_en_n | input | 2 | Per-half A-output drive enable, active low |
| a_in | input | 16 | A bus input |
| b_in | input | 16 | B bus input |
| a_out | output | 16 | A bus output data |
| a_oe | output | 16 | A bus output enable, one bit per data bit |
| b_out | output | 16 | B bus output data |
| b_oe | output | 16 | B bus output enable, one bit per data bit |

## Verification
All output enables and pass-through outputs are combinational, so they are due in the same cycle as the control or input change that causes them. A stored value appears at the outputs as soon as the rising edge of the half clock that loads it has passed. The bench changes inputs on the falling edge of its reference clock and pulses any half clock 1 ns later. It then compares every output against its model on the next rising edge, by which time the edge-loaded values and the combinational paths have settled. The model updates its stored copy at the moment it raises a half clock, so a stored-mode comparison always uses the value that was last captured.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int LANE_W_DEF = 8;
    localparam int HALVES_DEF = 2;

    typedef enum logic {
        SEL_LIVE   = 1'b0,
        SEL_STORED = 1'b1
    } path_sel_e;

    typedef struct packed {
        path_sel_e src;
        logic      drive;
    } dir_ctrl_t;

    function automatic dir_ctrl_t ctrl_hi(input logic sel, input logic en);
        dir_ctrl_t c;
        c.src   = path_sel_e'(sel);
        c.drive = en;
        return c;
    endfunction

    function automatic dir_ctrl_t ctrl_lo(input logic sel, input logic en_n);
        dir_ctrl_t c;
        c.src   = path_sel_e'(sel);
        c.drive = ~en_n;
        return c;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         cap_clk,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] src_in,
    output logic [W-1:0] dst_out,
    output logic [W-1:0] dst_oe
);
    logic [W-1:0] held;

    xcvr_capture_reg #(.W(W)) u_hold (
        .clk (cap_clk),
        .d   (src_in),
        .q   (held)
    );

    always_comb begin
        unique case (ctrl.src)
            SEL_STORED: dst_out = held;
            default:    dst_out = src_in;
        endcase
        dst_oe = {W{ctrl.drive}};
    end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         ab_clk,
    input  logic         ba_clk,
    input  logic         ab_sel,
    input  logic         ba_sel,
    input  logic         ab_en,
    input  logic         ba_en_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    dir_ctrl_t ab_ctrl;
    dir_ctrl_t ba_ctrl;

    assign ab_ctrl = ctrl_hi(ab_sel, ab_en);
    assign ba_ctrl = ctrl_lo(ba_sel, ba_en_n);

    xcvr_dir_path #(.W(W)) u_a2b (
        .cap_clk (ab_clk),
        .ctrl    (ab_ctrl),
        .src_in  (a_in),
        .dst_out (b_out),
        .dst_oe  (b_oe)
    );

    xcvr_dir_path #(.W(W)) u_b2a (
        .cap_clk (ba_clk),
        .ctrl    (ba_ctrl),
        .src_in  (b_in),
        .dst_out (a_out),
        .dst_oe  (a_oe)
    );

    // Both directions live and driven: the two paths must mirror each other.
    always_comb begin
        if (!ab_sel && !ba_sel && ab_en && !ba_en_n) begin
            assert_loop_mirror_R8: assert ((b_out == a_in) && (a_out == b_in) && (&a_oe) && (&b_oe));
        end
    end
endmodule

// File: rtl/xcvr_dual_byte.sv
module xcvr_dual_byte
    import xcvr_pkg::*;
#(
    parameter int HALVES = HALVES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int BUS_W = HALVES * LANE_W
) (
    input  logic [HALVES-1:0] ab_clk,
    input  logic [HALVES-1:0] ba_clk,
    input  logic [HALVES-1:0] ab_sel,
    input  logic [HALVES-1:0] ba_sel,
    input  logic [HALVES-1:0] ab_en,
    input  logic [HALVES-1:0] ba_en_n,
    input  logic [BUS_W-1:0]  a_in,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [BUS_W-1:0]  a_oe,
    output logic [BUS_W-1:0]  b_out,
    output logic [BUS_W-1:0]  b_oe
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [LANE_W-1:0] a_o, a_e, b_o, b_e;

        xcvr_half #(.W(LANE_W)) u_half (
            .ab_clk  (ab_clk[h]),
            .ba_clk  (ba_clk[h]),
            .ab_sel  (ab_sel[h]),
            .ba_sel  (ba_sel[h]),
            .ab_en   (ab_en[h]),
            .ba_en_n (ba_en_n[h]),
            .a_in    (a_in[h*LANE_W +: LANE_W]),
            .b_in    (b_in[h*LANE_W +: LANE_W]),
            .a_out   (a_o),
            .a_oe    (a_e),
            .b_out   (b_o),
            .b_oe    (b_e)
        );

        assign a_out[h*LANE_W +: LANE_W] = a_o;
        assign a_oe [h*LANE_W +: LANE_W] = a_e;
        assign b_out[h*LANE_W +: LANE_W] = b_o;
        assign b_oe [h*LANE_W +: LANE_W] = b_e;

        // Each byte's enables switch as one group, following its own half's control.
        always_comb begin
            assert_b_group_R6: assert ((b_e == '0) || (b_e == '1));
            assert_a_group_R7: assert ((a_e == '0) || (a_e == '1));
            assert_b_polarity_R6: assert ((&b_e) == ab_en[h]);
            assert_a_polarity_R7: assert ((&a_e) == !ba_en_n[h]);
            if (ab_en[h] && !ab_sel[h]) begin
                assert_b_live_R3: assert (b_out[h*LANE_W +: LANE_W] == a_in[h*LANE_W +: LANE_W]);
            end
        end
    end
endmodule

// File: tb/tb_xcvr_dual_byte.sv
module tb_xcvr_dual_byte;
    localparam int H = 2;
    localparam int L = 8;
    localparam int W = H * L;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [H-1:0] ab_clk = '0, ba_clk = '0;
    logic [H-1:0] ab_sel = '0, ba_sel = '0;
    logic [H-1:0] ab_en = '0, ba_en_n = '1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    xcvr_dual_byte dut (
        .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_sel(ab_sel), .ba_sel(ba_sel),
        .ab_en(ab_en), .ba_en_n(ba_en_n), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    int vectors = 0;
    int miscompares = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    logic [L-1:0] ref_a [H];
    logic [L-1:0] ref_b [H];

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Per-clock model comparison of every half and direction.
    always @(posedge clk) begin
        if (running) begin
            for (int h = 0; h < H; h++) begin
                logic [L-1:0] eb, ea;
                eb = ab_sel[h] ? ref_a[h] : a_in[h*L +: L];
                ea = ba_sel[h] ? ref_b[h] : b_in[h*L +: L];
                chk("R6 b_oe", {8'h0, b_oe[h*L +: L]}, {8'h0, {L{ab_en[h]}}});
                chk("R7 a_oe", {8'h0, a_oe[h*L +: L]}, {8'h0, {L{~ba_en_n[h]}}});
                if (ab_en[h])
                    chk(ab_sel[h] ? "R4 b_out stored" : "R3 b_out live",
                        {8'h0, b_out[h*L +: L]}, {8'h0, eb});
                if (!ba_en_n[h])
                    chk("R5 a_out", {8'h0, a_out[h*L +: L]}, {8'h0, ea});
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_ab(input int h);
        #1;
        ref_a[h] = a_in[h*L +: L];
        ab_clk[h] = 1'b1;
        #1;
        ab_clk[h] = 1'b0;
    endtask

    task automatic pulse_ba(input int h);
        #1;
        ref_b[h] = b_in[h*L +: L];
        ba_clk[h] = 1'b1;
        #1;
        ba_clk[h] = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;

        step();
        settle();
        chk("R6 idle b_oe", b_oe, '0);
        chk("R7 idle a_oe", a_oe, '0);

        // Load every register before any storage-mode read.
        step();
        a_in = 16'h1234; b_in = 16'h5678;
        for (int h = 0; h < H; h++) begin pulse_ab(h); pulse_ba(h); end
        running = 1'b1;

        // Live, then stored, in both directions.
        ab_en = '1; ba_en_n = '0;
        for (int s = 0; s < 2; s++) begin
            ab_sel = {H{s[0]}}; ba_sel = {H{s[0]}};
            for (int p = 0; p < 4; p++) begin
                step();
                a_in = {pats[p], ~pats[p]};
                b_in = {~pats[p], pats[p]};
                settle();
                if (s == 0) begin
                    chk("R3 live copy", b_out, a_in);
                    chk("R8 mirror", a_out, b_in);
                end
            end
        end

        // R1: capture while disabled and in live mode, replay later.
        step();
        ab_en = '0; ab_sel = '0; a_in = 16'hC33C;
        pulse_ab(0); pulse_ab(1);
        step();
        a_in = 16'h0F0F; ab_sel = '1; ab_en = '1;
        settle();
        chk("R1 replay", b_out, 16'hC33C);

        // R2: capture while A outputs are off.
        step();
        ba_en_n = '1; ba_sel = '0; b_in = 16'h9669;
        pulse_ba(0); pulse_ba(1);
        step();
        b_in = 16'h1111; ba_sel = '1; ba_en_n = '0;
        settle();
        chk("R2 replay", a_out, 16'h9669);

        // R9: churn half 1 while half 0 holds stored values.
        step();
        a_in = {8'hEE, a_in[7:0]}; b_in = {8'hDD, b_in[7:0]};
        ab_sel[1] = 1'b0; ba_sel[1] = 1'b0; ab_en[1] = 1'b0; ba_en_n[1] = 1'b1;
        pulse_ab(1); pulse_ba(1);
        settle();
        chk("R9 half0 b", {8'h0, b_out[7:0]}, 16'h003C);
        chk("R9 half0 a", {8'h0, a_out[7:0]}, 16'h0069);
        chk("R9 half0 oe", {a_oe[7:0], b_oe[7:0]}, 16'hFFFF);

        // Random traffic on both halves.
        for (int i = 0; i < 400; i++) begin
            step();
            a_in = W'($urandom); b_in = W'($urandom);
            ab_sel = H'($urandom); ba_sel = H'($urandom);
            ab_en = H'($urandom); ba_en_n = H'($urandom);
            for (int h = 0; h < H; h++) begin
                if ($urandom_range(0, 2) == 0) pulse_ab(h);
                if ($urandom_range(0, 2) == 0) pulse_ba(h);
            end
        end

        step();
        running = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule